// File: doc/BRIEF.md
# UART FIFO Pair with Trigger Flags

This block holds the byte buffering of a serial port. A 16-entry transmit queue is filled by software and drained by the serializer. A 16-entry receive queue is filled by the serializer and drained by software. An 8-bit control register sets the trigger level of each queue. It can also empty either queue and hold it empty, and it carries a loopback enable that is only passed out to the serial logic.

Two flags are computed from each queue's live occupancy and its selected trigger level. The receive-ready flag rises when the receive queue holds at least its trigger count. The transmit-low flag is high while the transmit queue holds no more than its trigger count. Both occupancy counts are also output. Pushes and pops are single-cycle strobes. A push to a full queue is dropped. A pop from an empty queue changes nothing.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset the control register reads 0x00, both counts are 0, rxReadyFlag is 0, txLowFlag is 1 and loopbackEn is 0.
- R2: A register write stores every bit except bit 3. regRdData shows the stored value from the next cycle on, and bit 3 always reads 0.
- R3: loopbackEn follows control bit 0.
- R4: Control bits 7:6 pick the receive trigger: 00=1, 01=4, 10=8, 11=14 bytes. rxReadyFlag is 1 exactly when rxCount is at or above the trigger.
- R5: Control bits 5:4 pick the transmit trigger: 00=8, 01=4, 10=2, 11=1 bytes. txLowFlag is 1 exactly when txCount is at or below the trigger.
- R6: Each queue is first-in first-out. The byte taken by a pop appears on its pop data output in the cycle after the pop strobe.
- R7: A push to a queue holding 16 bytes is dropped. The count never exceeds 16, and the stored bytes are unchanged.
- R8: A pop from an empty queue leaves its count at 0 and its pop data output unchanged.
- R9: Control bit 2 empties the transmit queue and bit 1 empties the receive queue. The count reads 0 in the cycle after the write that sets the bit. While the bit stays 1, pushes to that queue are ignored. The other queue is not affected.
- R10: A push and a pop in the same cycle are both taken when the queue is neither empty nor full, leaving the count unchanged. On an empty queue only the push is taken. On a full queue only the pop is taken.
- R11: The flags follow registered counts and register state. They change in the cycle after the push, pop or trigger write that moves them, and not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read value |
| txPushValid | input | 1 | Software writes a byte into the transmit queue |
| txPushData | input | 8 | Byte for the transmit queue |
| txPopReq | input | 1 | Serializer takes a byte from the transmit queue |
| txPopData | output | 8 | Last byte taken from the transmit queue |
| rxPushValid | input | 1 | Serializer delivers a byte into the receive queue |
| rxPushData | input | 8 | Byte for the receive queue |
| rxPopReq | input | 1 | Software takes a byte from the receive queue |
| rxPopData | output | 8 | Last byte taken from the receive queue |
| txCount | output | 5 | Transmit queue occupancy, 0 to 16 |
| rxCount | output | 5 | Receive queue occupancy, 0 to 16 |
| rxReadyFlag | output | 1 | Receive occupancy is at or above its trigger |
| txLowFlag | output | 1 | Transmit occupancy is at or below its trigger |
| loopbackEn | output | 1 | Loopback enable from control bit 0 |

## Verification
The flag logic is swept by a table. For every trigger code of each queue, the queue is filled to exactly the trigger level and to one byte on the wrong side of it. This separates at-or-above from strictly-above on the receive side and at-or-below from strictly-below on the transmit side, and it catches swapped encodings. Directed sequences fill the transmit queue past 16 and drain it, pop an empty queue, and overlap pushes with pops at the empty, middle and full levels. Others hold a queue empty through its control bit while pushing to both queues, and check that a flag does not move until the cycle after the event that causes it.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

  // Which queue an array index refers to
  localparam int TX_IDX = 0;
  localparam int RX_IDX = 1;

  // Control register bit positions
  localparam int BIT_LOOP    = 0;
  localparam int BIT_RXFLUSH = 1;
  localparam int BIT_TXFLUSH = 2;
  localparam int BIT_RSVD    = 3;

  // Strobes from control to one queue
  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
  } fifoStb_t;

  function automatic int unsigned rxThreshold(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int unsigned txThreshold(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
  import fifo_pair_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStb_t         stb,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] popData,
  output logic [$clog2(DEPTH):0] count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] outReg;
  logic isFull, isEmpty, doPush, doPop;

  assign isFull  = (cnt == CNT_W'(DEPTH));
  assign isEmpty = (cnt == '0);
  assign doPush  = stb.push && !isFull && !stb.flush;
  assign doPop   = stb.pop && !isEmpty && !stb.flush;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      cnt    <= '0;
      outReg <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) begin
        if (wrPtr == PTR_W'(DEPTH - 1)) wrPtr <= '0;
        else                            wrPtr <= wrPtr + 1'b1;
      end
      if (doPop) begin
        outReg <= mem[rdPtr];
        if (rdPtr == PTR_W'(DEPTH - 1)) rdPtr <= '0;
        else                            rdPtr <= rdPtr + 1'b1;
      end
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign popData = outReg;
  assign count   = cnt;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH) && stb.push && !stb.pop && !stb.flush) |=> count == CNT_W'(DEPTH)); // R7
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && stb.pop && !stb.push) |=> (count == '0 && $stable(popData))); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> count == '0); // R9
  AST_PUSH_POP_BALANCE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && stb.pop && !stb.flush && count != '0 && count != CNT_W'(DEPTH)) |=> $stable(count)); // R10
endmodule

// File: rtl/fifo_pair_datapath.sv
module fifo_pair_datapath
  import fifo_pair_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStb_t         stb      [2],
  input  logic [WIDTH-1:0] pushData [2],
  output logic [WIDTH-1:0] popData  [2],
  output logic [CNT_W-1:0] count    [2]
);
  for (genvar g = 0; g < 2; g++) begin : gQueue
    byte_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uFifo (
      .clk      (clk),
      .rstN     (rstN),
      .stb      (stb[g]),
      .pushData (pushData[g]),
      .popData  (popData[g]),
      .count    (count[g])
    );
  end
endmodule

// File: rtl/fifo_pair_ctrl.sv
module fifo_pair_ctrl
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             txPushValid,
  input  logic             txPopReq,
  input  logic             rxPushValid,
  input  logic             rxPopReq,
  input  logic [CNT_W-1:0] count [2],
  output fifoStb_t         stb   [2],
  output logic             rxReadyFlag,
  output logic             txLowFlag,
  output logic             loopbackEn
);
  localparam logic [7:0] WR_MASK = ~(8'd1 << BIT_RSVD);

  logic [7:0] ctrlReg;
  logic txFlushNow, rxFlushNow;
  logic [CNT_W-1:0] rxThr, txThr;

  always_ff @(posedge clk) begin
    if (!rstN)        ctrlReg <= '0;
    else if (regWrEn) ctrlReg <= regWrData & WR_MASK;
  end

  // A queue is emptied at the very edge of the write that sets its bit
  assign txFlushNow = ctrlReg[BIT_TXFLUSH] | (regWrEn & regWrData[BIT_TXFLUSH]);
  assign rxFlushNow = ctrlReg[BIT_RXFLUSH] | (regWrEn & regWrData[BIT_RXFLUSH]);

  always_comb begin
    stb[TX_IDX].flush = txFlushNow;
    stb[TX_IDX].push  = txPushValid & ~txFlushNow;
    stb[TX_IDX].pop   = txPopReq & ~txFlushNow;
    stb[RX_IDX].flush = rxFlushNow;
    stb[RX_IDX].push  = rxPushValid & ~rxFlushNow;
    stb[RX_IDX].pop   = rxPopReq & ~rxFlushNow;
  end

  assign rxThr = CNT_W'(rxThreshold(ctrlReg[7:6]));
  assign txThr = CNT_W'(txThreshold(ctrlReg[5:4]));

  assign rxReadyFlag = (count[RX_IDX] >= rxThr);
  assign txLowFlag   = (count[TX_IDX] <= txThr);
  assign loopbackEn  = ctrlReg[BIT_LOOP];
  assign regRdData   = ctrlReg;

  AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == ($past(regWrData) & 8'hF7)); // R2
  AST_RX_EMPTY_NOFLAG: assert property (@(posedge clk) disable iff (!rstN)
    count[RX_IDX] == '0 |-> !rxReadyFlag); // R4
  AST_TX_FULL_NOFLAG: assert property (@(posedge clk) disable iff (!rstN)
    count[TX_IDX] == CNT_W'(DEPTH) |-> !txLowFlag); // R5
  AST_HELD_QUEUE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[BIT_RXFLUSH] && $past(regRdData[BIT_RXFLUSH])) |-> count[RX_IDX] == '0); // R9
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             txPushValid,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPopReq,
  output logic [WIDTH-1:0] txPopData,
  input  logic             rxPushValid,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPopReq,
  output logic [WIDTH-1:0] rxPopData,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             rxReadyFlag,
  output logic             txLowFlag,
  output logic             loopbackEn
);
  fifoStb_t         stb      [2];
  logic [CNT_W-1:0] count    [2];
  logic [WIDTH-1:0] pushData [2];
  logic [WIDTH-1:0] popData  [2];

  assign pushData[TX_IDX] = txPushData;
  assign pushData[RX_IDX] = rxPushData;
  assign txPopData = popData[TX_IDX];
  assign rxPopData = popData[RX_IDX];
  assign txCount   = count[TX_IDX];
  assign rxCount   = count[RX_IDX];

  fifo_pair_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .txPushValid (txPushValid),
    .txPopReq    (txPopReq),
    .rxPushValid (rxPushValid),
    .rxPopReq    (rxPopReq),
    .count       (count),
    .stb         (stb),
    .rxReadyFlag (rxReadyFlag),
    .txLowFlag   (txLowFlag),
    .loopbackEn  (loopbackEn)
  );

  fifo_pair_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pushData (pushData),
    .popData  (popData),
    .count    (count)
  );
endmodule

// File: tb/tb_uart_fifo_pair.sv
module tb_uart_fifo_pair;
  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic txPushValid = 0, txPopReq = 0, rxPushValid = 0, rxPopReq = 0;
  logic [7:0] txPushData = '0, rxPushData = '0;
  logic [7:0] txPopData, rxPopData;
  logic [4:0] txCount, rxCount;
  logic rxReadyFlag, txLowFlag, loopbackEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_fifo_pair dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .txPushValid(txPushValid), .txPushData(txPushData), .txPopReq(txPopReq), .txPopData(txPopData),
    .rxPushValid(rxPushValid), .rxPushData(rxPushData), .rxPopReq(rxPopReq), .rxPopData(rxPopData),
    .txCount(txCount), .rxCount(rxCount), .rxReadyFlag(rxReadyFlag), .txLowFlag(txLowFlag),
    .loopbackEn(loopbackEn)
  );

  // Entry: {isRx, triggerCode[1:0], fillLevel[4:0], expectedFlag}
  localparam logic [8:0] VEC [18] = '{
    9'b1_00_00000_0, 9'b1_00_00001_1, 9'b1_01_00011_0, 9'b1_01_00100_1,
    9'b1_10_00111_0, 9'b1_10_01000_1, 9'b1_11_01101_0, 9'b1_11_01110_1,
    9'b1_11_10000_1,
    9'b0_00_01000_1, 9'b0_00_01001_0, 9'b0_01_00100_1, 9'b0_01_00101_0,
    9'b0_10_00010_1, 9'b0_10_00011_0, 9'b0_11_00001_1, 9'b0_11_00010_0,
    9'b0_11_00000_1
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] d);
    regWrEn = 1; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic pushN(input bit isRx, input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      if (isRx) begin rxPushValid = 1; rxPushData = base + 8'(i); end
      else      begin txPushValid = 1; txPushData = base + 8'(i); end
      @(negedge clk);
    end
    rxPushValid = 0; txPushValid = 0;
  endtask

  task automatic popOne(input bit isRx);
    if (isRx) rxPopReq = 1; else txPopReq = 1;
    @(negedge clk);
    rxPopReq = 0; txPopReq = 0;
  endtask

  task automatic flushAll(input logic [7:0] trig);
    writeReg(trig | 8'h06);
    writeReg(trig);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 regRdData", regRdData, 0);
    chk("R1 txCount", txCount, 0);
    chk("R1 rxCount", rxCount, 0);
    chk("R1 rxReadyFlag", rxReadyFlag, 0);
    chk("R1 txLowFlag", txLowFlag, 1);
    chk("R1 loopbackEn", loopbackEn, 0);

    // R4 R5 trigger sweep from the table
    for (int v = 0; v < 18; v++) begin
      logic [8:0] e;
      logic [7:0] trig;
      e = VEC[v];
      trig = e[8] ? {e[7:6], 6'b0} : {2'b0, e[7:6], 4'b0};
      flushAll(trig);
      pushN(e[8], int'(e[5:1]), 8'h10);
      if (e[8]) begin
        chk($sformatf("R4 rx flag code=%0d fill=%0d", e[7:6], e[5:1]), rxReadyFlag, e[0]);
        chk("R4 rx count", rxCount, int'(e[5:1]));
      end else begin
        chk($sformatf("R5 tx flag code=%0d fill=%0d", e[7:6], e[5:1]), txLowFlag, e[0]);
        chk("R5 tx count", txCount, int'(e[5:1]));
      end
    end

    // R2 R3 register access, reserved bit
    writeReg(8'hF9);
    chk("R2 read back reserved masked", regRdData, 8'hF1);
    chk("R3 loopback on", loopbackEn, 1);
    writeReg(8'h08);
    chk("R2 reserved only", regRdData, 0);
    chk("R3 loopback off", loopbackEn, 0);
    writeReg(8'h51);
    chk("R2 mixed value", regRdData, 8'h51);
    chk("R3 loopback again", loopbackEn, 1);

    // R6 order and pop latency
    flushAll(8'h00);
    pushN(1, 3, 8'hA0);
    popOne(1);
    chk("R6 first byte", rxPopData, 8'hA0);
    popOne(1);
    chk("R6 second byte", rxPopData, 8'hA1);
    popOne(1);
    chk("R6 third byte", rxPopData, 8'hA2);

    // R7 overflow drop
    flushAll(8'h00);
    pushN(0, 17, 8'h01);
    chk("R7 count capped", txCount, 16);
    chk("R5 R7 full tx flag", txLowFlag, 0);
    for (int i = 0; i < 16; i++) begin
      popOne(0);
      chk($sformatf("R7 drain byte %0d", i), txPopData, i + 1);
    end
    chk("R7 drained", txCount, 0);

    // R8 empty pop
    popOne(0);
    chk("R8 empty pop data", txPopData, 16);
    chk("R8 empty pop count", txCount, 0);

    // R9 per-queue flush and hold
    flushAll(8'h00);
    pushN(0, 2, 8'h30);
    pushN(1, 3, 8'h40);
    writeReg(8'h02);
    chk("R9 rx emptied", rxCount, 0);
    chk("R9 tx untouched", txCount, 2);
    pushN(1, 2, 8'h50);
    chk("R9 pushes ignored while held", rxCount, 0);
    writeReg(8'h00);
    pushN(1, 1, 8'h60);
    chk("R9 push after release", rxCount, 1);
    writeReg(8'h04);
    chk("R9 tx emptied", txCount, 0);
    chk("R9 rx untouched by tx flush", rxCount, 1);
    writeReg(8'h00);

    // R10 simultaneous push and pop
    flushAll(8'h00);
    pushN(1, 2, 8'h01);
    rxPushValid = 1; rxPushData = 8'h09; rxPopReq = 1;
    @(negedge clk);
    rxPushValid = 0; rxPopReq = 0;
    chk("R10 mid count steady", rxCount, 2);
    chk("R10 mid pop data", rxPopData, 8'h01);
    flushAll(8'h00);
    rxPushValid = 1; rxPushData = 8'h77; rxPopReq = 1;
    @(negedge clk);
    rxPushValid = 0; rxPopReq = 0;
    chk("R10 empty push only", rxCount, 1);
    chk("R10 empty pop data held", rxPopData, 8'h01);
    popOne(1);
    chk("R10 pushed byte kept", rxPopData, 8'h77);
    flushAll(8'h00);
    pushN(0, 16, 8'h80);
    txPushValid = 1; txPushData = 8'hEE; txPopReq = 1;
    @(negedge clk);
    txPushValid = 0; txPopReq = 0;
    chk("R10 full pop only", txCount, 15);
    chk("R10 full pop data", txPopData, 8'h80);

    // R11 flag timing
    flushAll(8'h40);
    pushN(1, 3, 8'h00);
    chk("R11 below trigger", rxReadyFlag, 0);
    rxPushValid = 1; rxPushData = 8'h03;
    #1;
    chk("R11 no change in push cycle", rxReadyFlag, 0);
    @(negedge clk);
    rxPushValid = 0;
    chk("R11 flag after push", rxReadyFlag, 1);
    regWrEn = 1; regWrData = 8'h80;
    #1;
    chk("R11 no change in write cycle", rxReadyFlag, 1);
    @(negedge clk);
    regWrEn = 0;
    chk("R11 flag after trigger change", rxReadyFlag, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule